// File: doc/BRIEF.md
# I2C Target with Control-Register Port

This block lets an external I2C host read and write a bank of 8-bit control registers that live elsewhere in the chip. SCL and SDA are sampled on the fast system clock. Each line passes through a two-flop synchroniser and a short glitch filter before start, stop and clock edges are detected. The open-drain pad is modelled as two signals: an input that reads the pulled-up line, and an output-enable that pulls the line low when set.

A write transfer has three parts in this order: the device address with the direction bit clear, a sub-address byte that loads an internal pointer, and any number of data bytes. Each data byte is sent out on the register port with a single-cycle write strobe. A read transfer has no sub-address byte. It starts returning data from wherever the previous write left the pointer. The pointer steps up by one after every data byte, in both directions, so bursts reach consecutive registers.

The system clock must run at least 20 times faster than SCL.

Top module: `i2c_reg_port`

## Requirements
- R1: The block acknowledges the address byte (SDA held low during the ninth SCL high) only when its upper seven bits equal 1000000. Bit 0 of that byte selects the direction: 0 is write and 1 is read.
- R2: After an address that does not match, the block does not acknowledge. Until the next start it produces no acknowledge and no write strobe.
- R3: In a write, the byte after the address loads the pointer. Each later byte is acknowledged and produces one `reg_we` pulse that lasts exactly one clock cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R4: The pointer increments after each written byte, so a burst fills consecutive registers.
- R5: A read returns `reg_rdata` for the register at the pointer left by the previous write, most significant bit first, with no sub-address phase.
- R6: The pointer increments after each byte read. A host acknowledge makes the block send the next register, and a later read continues from the incremented pointer.
- R7: When the host does not acknowledge a read byte, the block releases SDA and keeps it released for any further SCL pulses until the next start.
- R8: A repeated start restarts address reception and leaves the pointer unchanged.
- R9: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After a stop, bytes clocked without a new start are neither acknowledged nor written.
- R10: The block changes `sda_oe` only while SCL is low.
- R11: SCL pulses shorter than `FILT` system-clock cycles are ignored.
- R12: After reset, `sda_oe` and `reg_we` are 0 and the pointer (`reg_addr`) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| scl_in | input | 1 | SCL line as read at the pad |
| sda_in | input | 1 | SDA line as read at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 8 | Register pointer, used for both reads and writes |
| reg_wdata | output | 8 | Data byte for a write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr` |

## Verification
The write transfers use a three-byte burst, so a missing increment or a stretched strobe shows up as a wrong register or an extra write. The read sequence covers several cases:
- An acknowledged burst ended by a non-acknowledge, which separates the continue path from the release path.
- A second read, which shows where the pointer was left.
- A sub-address write followed by a repeated start and a read, which shows the restart path leaves the pointer alone.

Further transfers send a mismatched address, clock bytes after a stop, and place a one-cycle SCL glitch inside a data bit. Each of these must produce no acknowledge, no write, and no corrupted byte respectively.

// File: rtl/i2c_reg_port.sv
module i2c_reg_port #(
  parameter logic [6:0] DEV_ADDR = 7'b1000000,
  parameter int         FILT     = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  localparam int FW = $clog2(FILT + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK} st_t;
  typedef enum logic [1:0] {P_ADDR, P_SUB, P_DATA} ph_t;

  logic [1:0]    scl_s, sda_s;
  logic [FW-1:0] scl_c, sda_c;
  logic          scl_f, sda_f, scl_q, sda_q;
  st_t           st;
  ph_t           ph;
  logic [2:0]    cnt;
  logic [7:0]    shr, txs, ptr;
  logic          full, rw, nack;

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
    end else begin
      scl_s <= {scl_s[0], scl_in};
      sda_s <= {sda_s[0], sda_in};
    end

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      scl_f <= 1'b1; scl_c <= '0;
      sda_f <= 1'b1; sda_c <= '0;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (scl_s[1] == scl_f) scl_c <= '0;
      else if (scl_c == FW'(FILT - 1)) begin scl_f <= scl_s[1]; scl_c <= '0; end
      else scl_c <= scl_c + 1'b1;
      if (sda_s[1] == sda_f) sda_c <= '0;
      else if (sda_c == FW'(FILT - 1)) begin sda_f <= sda_s[1]; sda_c <= '0; end
      else sda_c <= sda_c + 1'b1;
    end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_c  = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      st <= S_IDLE; ph <= P_ADDR; cnt <= '0; shr <= '0; txs <= '1;
      ptr <= '0; full <= 1'b0; rw <= 1'b0; nack <= 1'b0;
      reg_we <= 1'b0; reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) ptr <= ptr + 8'd1;
      if (start_c) begin
        st <= S_RX; ph <= P_ADDR; cnt <= '0; full <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_RX:
            if (scl_rise) begin
              shr <= {shr[6:0], sda_f};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) full <= 1'b1;
            end else if (scl_fall && full) begin
              full <= 1'b0;
              cnt  <= '0;
              case (ph)
                P_ADDR:
                  if (shr[7:1] == DEV_ADDR) begin rw <= shr[0]; st <= S_ACK; end
                  else st <= S_IDLE;
                P_SUB:   begin ptr <= shr; st <= S_ACK; end
                default: begin reg_we <= 1'b1; reg_wdata <= shr; st <= S_ACK; end
              endcase
            end
          S_ACK:
            if (scl_fall) begin
              cnt <= '0;
              if (ph == P_ADDR && rw) begin
                st  <= S_TX;
                txs <= reg_rdata;
              end else begin
                st <= S_RX;
                ph <= (ph == P_ADDR) ? P_SUB : P_DATA;
              end
            end
          S_TX:
            if (scl_fall) begin
              txs <= {txs[6:0], 1'b1};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin st <= S_RACK; ptr <= ptr + 8'd1; end
            end
          S_RACK:
            if (scl_rise) nack <= sda_f;
            else if (scl_fall) begin
              if (nack) st <= S_IDLE;
              else begin st <= S_TX; txs <= reg_rdata; cnt <= '0; end
            end
          default: ;
        endcase
      end
    end

  assign sda_oe   = (st == S_ACK) | ((st == S_TX) & ~txs[7]);
  assign reg_addr = ptr;

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
  a_r4_ptr_steps: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> reg_addr == $past(reg_addr) + 8'd1);
  a_r3_strobe_acked: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> sda_oe);
  a_r8_start_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    (start_c && !reg_we) |=> reg_addr == $past(reg_addr));
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(start_c) && !$past(stop_c)) |-> !scl_f);
endmodule

// File: tb/i2c_reg_port_bench.sv
module i2c_reg_port_bench;
  localparam int CLK_P = 10;
  localparam int Q = 12;
  localparam int H = 24;

  logic clk = 0, rst = 1;
  logic scl_drv = 1, sda_drv = 1;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] regs [256];
  wire sda_bus = sda_drv & ~sda_oe;

  int total = 0, bad = 0, we_cnt = 0, wide = 0, r10_bad = 0, cyc = 0;
  logic we_prev = 0, oe_prev = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_reg_port u_i2c_reg_port (
    .clk(clk), .rst(rst), .scl_in(scl_drv), .sda_in(sda_bus),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata));

  assign reg_rdata = regs[reg_addr];

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  initial for (int i = 0; i < 256; i++) regs[i] = pat(i);

  always @(posedge clk) begin
    if (reg_we) begin
      we_cnt++;
      regs[reg_addr] <= reg_wdata;
      if (we_prev) wide++;
    end
    we_prev <= reg_we;
  end

  always @(negedge clk) begin
    if (!rst && scl_drv && sda_oe !== oe_prev) r10_bad++;
    oe_prev = sda_oe;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic i2c_start;
    sda_drv = 1; hold(Q); scl_drv = 1; hold(Q);
    sda_drv = 0; hold(Q); scl_drv = 0; hold(Q);
  endtask

  task automatic i2c_stop;
    sda_drv = 0; hold(Q); scl_drv = 1; hold(Q); sda_drv = 1; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; hold(Q); scl_drv = 1;
      if (glitch && i == 3) begin
        hold(H/2); scl_drv = 0; hold(1); scl_drv = 1; hold(H/2 - 1);
      end else hold(H);
      scl_drv = 0; hold(Q);
    end
    sda_drv = 1; hold(Q); scl_drv = 1; hold(H/2);
    ack = sda_bus; hold(H/2); scl_drv = 0; hold(Q);
  endtask

  task automatic read_byte(input bit host_ack, output logic [7:0] b);
    sda_drv = 1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q); scl_drv = 1; hold(H/2); b[i] = sda_bus; hold(H/2); scl_drv = 0;
    end
    hold(2); sda_drv = host_ack ? 1'b0 : 1'b1;
    hold(Q - 2); scl_drv = 1; hold(H); scl_drv = 0; hold(Q); sda_drv = 1;
  endtask

  task automatic t_reset;
    chk("R12 sda_oe", sda_oe, 0);
    chk("R12 reg_we", reg_we, 0);
    chk("R12 reg_addr", reg_addr, 0);
  endtask

  task automatic t_write_burst;
    logic a; int w0;
    w0 = we_cnt;
    i2c_start;
    send_byte(8'h80, 0, a); chk("R1 write address ack", a, 0);
    send_byte(8'h10, 0, a); chk("R3 sub-address ack", a, 0);
    send_byte(8'hA5, 0, a); chk("R3 data ack", a, 0);
    send_byte(8'h3C, 0, a);
    send_byte(8'h7E, 0, a);
    i2c_stop;
    chk("R3 write count", we_cnt - w0, 3);
    chk("R3 strobe width", wide, 0);
    chk("R3 reg 10", regs[8'h10], 8'hA5);
    chk("R4 reg 11", regs[8'h11], 8'h3C);
    chk("R4 reg 12", regs[8'h12], 8'h7E);
    chk("R4 pointer after burst", reg_addr, 8'h13);
  endtask

  task automatic t_read_burst;
    logic a; logic [7:0] d;
    i2c_start;
    send_byte(8'h81, 0, a); chk("R1 read address ack", a, 0);
    read_byte(1, d); chk("R5 first read byte", d, pat(8'h13));
    read_byte(0, d); chk("R6 second read byte", d, pat(8'h14));
    read_byte(0, d); chk("R7 released after nack", d, 8'hFF);
    i2c_stop;
    i2c_start;
    send_byte(8'h81, 0, a);
    read_byte(0, d); chk("R6 read continues from pointer", d, pat(8'h15));
    i2c_stop;
  endtask

  task automatic t_mismatch;
    logic a; int w0;
    w0 = we_cnt;
    i2c_start;
    send_byte(8'h84, 0, a); chk("R2 foreign address not acked", a, 1);
    send_byte(8'h10, 0, a); chk("R2 following byte not acked", a, 1);
    send_byte(8'h55, 0, a);
    i2c_stop;
    chk("R2 no write", we_cnt - w0, 0);
    chk("R2 reg 10 kept", regs[8'h10], 8'hA5);
  endtask

  task automatic t_restart;
    logic a; logic [7:0] d;
    i2c_start;
    send_byte(8'h80, 0, a);
    send_byte(8'h20, 0, a);
    i2c_start;
    send_byte(8'h81, 0, a); chk("R8 address acked after repeated start", a, 0);
    read_byte(0, d); chk("R8 pointer kept over restart", d, pat(8'h20));
    i2c_stop;
  endtask

  task automatic t_after_stop;
    logic a; int w0;
    i2c_start;
    send_byte(8'h80, 0, a);
    send_byte(8'h30, 0, a);
    send_byte(8'h11, 0, a);
    i2c_stop;
    chk("R9 write before stop", regs[8'h30], 8'h11);
    w0 = we_cnt;
    hold(Q);
    send_byte(8'h80, 0, a); chk("R9 no ack without start", a, 1);
    send_byte(8'h66, 0, a);
    i2c_stop;
    chk("R9 no write after stop", we_cnt - w0, 0);
    chk("R9 reg 31 kept", regs[8'h31], pat(8'h31));
  endtask

  task automatic t_glitch;
    logic a;
    i2c_start;
    send_byte(8'h80, 0, a);
    send_byte(8'h40, 0, a);
    send_byte(8'h96, 1, a); chk("R11 glitched byte acked", a, 0);
    send_byte(8'h69, 0, a); chk("R11 next byte acked", a, 0);
    i2c_stop;
    chk("R11 glitched byte value", regs[8'h40], 8'h96);
    chk("R11 next byte value", regs[8'h41], 8'h69);
  endtask

  initial begin
    hold(5); rst = 0; hold(5);
    t_reset;
    t_write_burst;
    t_read_burst;
    t_mismatch;
    t_restart;
    t_after_stop;
    t_glitch;
    chk("R10 sda_oe changes while scl high", r10_bad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule